// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Address-Width Discovery

This block fetches 16-bit words from a small three-wire serial EEPROM of the 93C46 kind. It drives the EEPROM's serial clock, chip select and data input pins, and reads the device's data output pin. The host places a word address on `addr` and pulses `start`. The block then runs the read protocol and presents the word on `rdata` together with a one-cycle `done` pulse.

Devices of this family come in several sizes, and they differ in how many address bits follow the read opcode. The block therefore does not need to be told the size. On the first read after reset it shifts the address assuming the widest part, which takes 8 bits. Once the last real address bit is in, the device drives its output low, and the block stops shifting at that point. The number of bits shifted so far is the address width. The block lets this first transfer complete, discards its data, and repeats the read at the width it found. From then on the width is reported and reused.

A sweep request reads every word of the device, from address 0 upward, and adds them modulo 2^16. It reports whether the image is intact, which is the case when the sum equals the expected signature.

Top module: `uw_eeprom_reader`

## Requirements
- R1: While and after synchronous reset, `ser_clk`, `ser_cs` and `ser_to_rom` are 0, `done` is 0 and `width_valid` is 0.
- R2: Each transfer raises `ser_cs` while `ser_clk` is low. It then presents three bits on `ser_to_rom`, one per rising clock, most significant first: a start bit 1, then the read opcode bits 1 and 0.
- R3: `ser_to_rom` changes only while `ser_clk` is low. `ser_clk` is high only while `ser_cs` is high. Every high period of `ser_clk` lasts at least `HALF_CYC` system clocks.
- R4: On the first read after reset, address bits are sent most significant first, starting from an 8-bit assumption. `ser_from_rom` is sampled after each address bit, once the clock is low again. Shifting stops at the first low sample. `width` then holds the number of address bits sent, and `width_valid` is set.
- R5: The probe transfer's data is discarded, and the same read is issued again at the discovered width. Only the low `width` bits of `addr` select the word, and higher address bits have no effect.
- R6: After the width is known, every later read uses exactly one chip-select cycle and no probe, until the next reset.
- R7: After the address, 16 data bits are clocked in most significant first. Each bit is sampled while `ser_clk` is high.
- R8: At the end of every transfer, `ser_cs`, `ser_clk` and `ser_to_rom` all return to 0.
- R9: If `ser_from_rom` never goes low within 8 address bits, `width_err` is set and `width` is taken as 8.
- R10: A start with `sweep` = 1 reads all 2^`width` words, at addresses 0 upward. `image_ok` is 1 after `done` exactly when the 16-bit wrapping sum of those words equals `GOOD_SUM` (0xBABA by default). `rdata` then holds the last word read.
- R11: A `start` pulse that arrives while a read or sweep is in progress is ignored.
- R12: `done` is a single-cycle pulse, and `rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read or sweep (pulse) |
| sweep | input | 1 | With `start`: read and sum the whole device |
| addr | input | MAX_AW | Word address |
| ser_from_rom | input | 1 | EEPROM data output |
| ser_clk | output | 1 | EEPROM serial clock |
| ser_cs | output | 1 | EEPROM chip select |
| ser_to_rom | output | 1 | EEPROM data input |
| done | output | 1 | Operation finished (one cycle) |
| rdata | output | WORD_W | Word read (last word in a sweep) |
| width | output | $clog2(MAX_AW+1) | Discovered address width |
| width_valid | output | 1 | Width has been discovered |
| width_err | output | 1 | No dummy zero seen within the 8-bit limit |
| image_ok | output | 1 | Sweep sum matched `GOOD_SUM` |

## Verification
The bench builds the block with `HALF_CYC` = 4. This keeps a full 64-word sweep to a few tens of thousands of cycles while still leaving the two-stage input synchronizer margin before each sample point. `MAX_AW` stays at 8, so the bench's device model can be switched between 4-bit, 6-bit and 8-bit address widths, and to a silent mode that never drives the dummy zero. This brings the smallest, typical and full-width discovery cases within reach, as well as the fallback to width 8.

// File: rtl/uw_eeprom_pkg.sv
package uw_eeprom_pkg;

    // Serial engine sequencing
    typedef enum logic [2:0] {
        E_IDLE,
        E_SEL,
        E_CMD,
        E_ADR,
        E_DAT,
        E_END
    } eng_st_t;

    // Host-side controller sequencing
    typedef enum logic [1:0] {
        T_IDLE,
        T_PROBE,
        T_READ
    } ctl_st_t;

    // Three phases of every serial bit slot
    typedef enum logic [1:0] {
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } bit_ph_t;

    // Start bit followed by the read opcode, sent from bit 2 down to bit 0
    localparam logic [2:0] READ_CMD = 3'b110;
    localparam int         CMD_BITS = 3;

    function automatic bit_ph_t ph_next(input bit_ph_t p);
        case (p)
            PH_SETUP: return PH_HIGH;
            PH_HIGH:  return PH_LOW;
            default:  return PH_SETUP;
        endcase
    endfunction

endpackage

// File: rtl/uw_phase_timer.sv
module uw_phase_timer #(
    parameter int HALF_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/uw_serial_engine.sv
module uw_serial_engine
    import uw_eeprom_pkg::*;
#(
    parameter int MAX_AW   = 8,
    parameter int WORD_W   = 16,
    parameter int HALF_CYC = 125
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              go,
    input  logic [MAX_AW-1:0]                 adr,
    input  logic [$clog2(MAX_AW+1)-1:0]       abits,
    input  logic                              from_rom,
    output logic                              sclk,
    output logic                              cs,
    output logic                              to_rom,
    output logic                              fin,
    output logic [WORD_W-1:0]                 word,
    output logic                              dz_seen,
    output logic [$clog2(MAX_AW+1)-1:0]       nbits
);
    localparam int AWB = $clog2(MAX_AW + 1);
    localparam int AIW = (MAX_AW > 1) ? $clog2(MAX_AW) : 1;
    localparam int IW  = $clog2((WORD_W > MAX_AW) ? WORD_W : MAX_AW);

    eng_st_t           st;
    bit_ph_t           ph;
    logic [IW-1:0]     idx;
    logic [MAX_AW-1:0] adr_q;
    logic [AWB-1:0]    ab_q;
    logic              rx_q1, rx_q2;
    logic              tick;

    uw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (st != E_IDLE),
        .tick (tick)
    );

    // Two-stage synchronizer on the EEPROM output pin
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q1 <= 1'b1;
            rx_q2 <= 1'b1;
        end else begin
            rx_q1 <= from_rom;
            rx_q2 <= rx_q1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            ph      <= PH_SETUP;
            idx     <= '0;
            adr_q   <= '0;
            ab_q    <= '0;
            word    <= '0;
            dz_seen <= 1'b0;
            nbits   <= '0;
        end else begin
            case (st)
                E_IDLE: if (go) begin
                    st      <= E_SEL;
                    ph      <= PH_SETUP;
                    adr_q   <= adr;
                    ab_q    <= abits;
                    dz_seen <= 1'b0;
                    nbits   <= '0;
                end
                E_SEL: if (tick) begin
                    st  <= E_CMD;
                    ph  <= PH_SETUP;
                    idx <= IW'(CMD_BITS - 1);
                end
                E_CMD: if (tick) begin
                    ph <= ph_next(ph);
                    if (ph == PH_LOW) begin
                        if (idx == '0) begin
                            st  <= E_ADR;
                            idx <= IW'(ab_q - 1'b1);
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                E_ADR: if (tick) begin
                    ph <= ph_next(ph);
                    if (ph == PH_LOW) begin
                        nbits <= nbits + 1'b1;
                        if (!rx_q2 || idx == '0) begin
                            dz_seen <= !rx_q2;
                            st      <= E_DAT;
                            idx     <= IW'(WORD_W - 1);
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                E_DAT: if (tick) begin
                    ph <= ph_next(ph);
                    if (ph == PH_HIGH)
                        word <= {word[WORD_W-2:0], rx_q2};
                    if (ph == PH_LOW) begin
                        if (idx == '0)
                            st <= E_END;
                        else
                            idx <= idx - 1'b1;
                    end
                end
                E_END: if (tick) st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // Pin decode from registered state
    always_comb begin
        cs     = (st == E_SEL) || (st == E_CMD) || (st == E_ADR) || (st == E_DAT);
        sclk   = ((st == E_CMD) || (st == E_ADR) || (st == E_DAT)) && (ph == PH_HIGH);
        to_rom = 1'b0;
        if (st == E_CMD)
            to_rom = READ_CMD[idx[1:0]];
        else if (st == E_ADR)
            to_rom = adr_q[idx[AIW-1:0]];
    end

    assign fin = (st == E_END) && tick;

    // R3: clock only inside a selected transfer
    a_r3_clk_needs_cs: assert property (@(posedge clk) disable iff (rst)
        sclk |-> cs);

    // R3: data toward the device holds while the clock is high
    a_r3_data_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(to_rom));

    // R8: releasing chip select leaves every pin low
    a_r8_release_low: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |-> (!sclk && !to_rom));

endmodule

// File: rtl/uw_sum_acc.sv
module uw_sum_acc #(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] GOOD_SUM = 'hBABA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] val,
    output logic              hit
);
    logic [WORD_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum <= '0;
        else if (add)
            sum <= sum + val;
    end

    assign hit = (sum == GOOD_SUM);

endmodule

// File: rtl/uw_eeprom_reader.sv
module uw_eeprom_reader
    import uw_eeprom_pkg::*;
#(
    parameter int                HALF_CYC = 125,
    parameter int                MAX_AW   = 8,
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] GOOD_SUM = 'hBABA
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            sweep,
    input  logic [MAX_AW-1:0]               addr,
    input  logic                            ser_from_rom,
    output logic                            ser_clk,
    output logic                            ser_cs,
    output logic                            ser_to_rom,
    output logic                            done,
    output logic [WORD_W-1:0]               rdata,
    output logic [$clog2(MAX_AW+1)-1:0]     width,
    output logic                            width_valid,
    output logic                            width_err,
    output logic                            image_ok
);
    localparam int AWB  = $clog2(MAX_AW + 1);
    localparam int IDXW = MAX_AW + 1;

    ctl_st_t           cst;
    logic [AWB-1:0]    aw_r;
    logic              known, err;
    logic              sweep_r, swept;
    logic [MAX_AW-1:0] addr_r;
    logic [IDXW-1:0]   idx, last_idx;
    logic              go_r;
    logic [MAX_AW-1:0] eng_adr;
    logic [AWB-1:0]    eng_bits;
    logic              done_r;
    logic [WORD_W-1:0] rdata_r;

    logic              fin, dz_seen, acc_hit;
    logic [WORD_W-1:0] word;
    logic [AWB-1:0]    nbits;
    logic              acc_clr, acc_add;

    uw_serial_engine #(
        .MAX_AW   (MAX_AW),
        .WORD_W   (WORD_W),
        .HALF_CYC (HALF_CYC)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .go       (go_r),
        .adr      (eng_adr),
        .abits    (eng_bits),
        .from_rom (ser_from_rom),
        .sclk     (ser_clk),
        .cs       (ser_cs),
        .to_rom   (ser_to_rom),
        .fin      (fin),
        .word     (word),
        .dz_seen  (dz_seen),
        .nbits    (nbits)
    );

    assign acc_clr = (cst == T_IDLE) && start;
    assign acc_add = (cst == T_READ) && fin && sweep_r;

    uw_sum_acc #(
        .WORD_W   (WORD_W),
        .GOOD_SUM (GOOD_SUM)
    ) u_acc (
        .clk (clk),
        .rst (rst),
        .clr (acc_clr),
        .add (acc_add),
        .val (word),
        .hit (acc_hit)
    );

    assign last_idx = (IDXW'(1) << aw_r) - IDXW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cst      <= T_IDLE;
            aw_r     <= '0;
            known    <= 1'b0;
            err      <= 1'b0;
            sweep_r  <= 1'b0;
            swept    <= 1'b0;
            addr_r   <= '0;
            idx      <= '0;
            go_r     <= 1'b0;
            eng_adr  <= '0;
            eng_bits <= '0;
            done_r   <= 1'b0;
            rdata_r  <= '0;
        end else begin
            go_r   <= 1'b0;
            done_r <= 1'b0;
            case (cst)
                T_IDLE: if (start) begin
                    sweep_r <= sweep;
                    swept   <= 1'b0;
                    addr_r  <= addr;
                    idx     <= '0;
                    go_r    <= 1'b1;
                    if (!known) begin
                        cst      <= T_PROBE;
                        eng_adr  <= addr;
                        eng_bits <= AWB'(MAX_AW);
                    end else begin
                        cst      <= T_READ;
                        eng_adr  <= sweep ? '0 : addr;
                        eng_bits <= aw_r;
                    end
                end
                T_PROBE: if (fin) begin
                    known   <= 1'b1;
                    go_r    <= 1'b1;
                    cst     <= T_READ;
                    eng_adr <= sweep_r ? '0 : addr_r;
                    if (dz_seen) begin
                        aw_r     <= nbits;
                        eng_bits <= nbits;
                    end else begin
                        aw_r     <= AWB'(MAX_AW);
                        eng_bits <= AWB'(MAX_AW);
                        err      <= 1'b1;
                    end
                end
                T_READ: if (fin) begin
                    if (sweep_r && idx != last_idx) begin
                        idx     <= idx + 1'b1;
                        eng_adr <= MAX_AW'(idx + 1'b1);
                        go_r    <= 1'b1;
                    end else begin
                        cst     <= T_IDLE;
                        done_r  <= 1'b1;
                        rdata_r <= word;
                        swept   <= sweep_r;
                    end
                end
                default: cst <= T_IDLE;
            endcase
        end
    end

    assign done        = done_r;
    assign rdata       = rdata_r;
    assign width       = aw_r;
    assign width_valid = known;
    assign width_err   = err;
    assign image_ok    = swept && acc_hit;

    // R12: completion flag never lasts two cycles
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: an error always comes with the full fallback width
    a_r9_err_full_width: assert property (@(posedge clk) disable iff (rst)
        width_err |-> (width_valid && width == AWB'(MAX_AW)));

    // R4: a discovered width lies within the supported range
    a_r4_width_range: assert property (@(posedge clk) disable iff (rst)
        width_valid |-> (width != '0 && width <= AWB'(MAX_AW)));

    // R6: once known, the width does not move until reset
    a_r6_width_locked: assert property (@(posedge clk) disable iff (rst)
        (width_valid && $past(width_valid)) |-> $stable(width));

endmodule

// File: tb/test_uw_eeprom_reader.sv
module test_uw_eeprom_reader;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sweep = 1'b0;
    logic [7:0]  addr = '0;
    logic        ser_from_rom = 1'b1;
    logic        ser_clk, ser_cs, ser_to_rom, done;
    logic [15:0] rdata;
    logic [3:0]  width;
    logic        width_valid, width_err, image_ok;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    uw_eeprom_reader #(.HALF_CYC(HALF)) i_uw_eeprom_reader (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sweep        (sweep),
        .addr         (addr),
        .ser_from_rom (ser_from_rom),
        .ser_clk      (ser_clk),
        .ser_cs       (ser_cs),
        .ser_to_rom   (ser_to_rom),
        .done         (done),
        .rdata        (rdata),
        .width        (width),
        .width_valid  (width_valid),
        .width_err    (width_err),
        .image_ok     (image_ok)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [0:255];
    int          dev_aw = 6;
    bit          mute = 1'b0;
    int          bcnt = 0;
    logic [2:0]  cmd_sh = '0;
    logic [7:0]  a_sh = '0;
    logic [15:0] dout_sh = '0;
    int          bad_cmd = 0;
    int          cs_rises = 0;

    function automatic logic [15:0] memfn(input int a);
        return 16'((a * 1877) ^ 16'hA5C3);
    endfunction

    always @(posedge ser_clk) begin
        if (ser_cs) begin
            if (bcnt < 3) begin
                cmd_sh = {cmd_sh[1:0], ser_to_rom};
                if (bcnt == 2 && cmd_sh != 3'b110) bad_cmd++;
            end else if (bcnt < 3 + dev_aw) begin
                a_sh = {a_sh[6:0], ser_to_rom};
                if (bcnt == 2 + dev_aw && !mute) begin
                    ser_from_rom = 1'b0;
                    dout_sh = mem[int'(a_sh) & ((1 << dev_aw) - 1)];
                end
            end else if (!mute) begin
                ser_from_rom = dout_sh[15];
                dout_sh = {dout_sh[14:0], 1'b0};
            end
            bcnt++;
        end
    end

    always @(negedge ser_cs) begin
        bcnt = 0;
        ser_from_rom = 1'b1;
    end

    always @(posedge ser_cs) cs_rises++;

    // ---------------- pin protocol monitor (R3) ----------------
    int   viol = 0;
    int   hi_run = 0;
    logic p_clk = 1'b0, p_di = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && p_clk && ser_to_rom != p_di) viol++;
            if (ser_clk && !ser_cs) viol++;
            if (ser_clk) hi_run++;
            else begin
                if (p_clk && hi_run < HALF) viol++;
                hi_run = 0;
            end
        end
        p_clk = ser_clk;
        p_di  = ser_to_rom;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] a, input logic sw, output logic [15:0] got);
        bit ok = 1'b0;
        got = '0;
        @(negedge clk);
        start = 1'b1; addr = a; sweep = sw;
        @(negedge clk);
        start = 1'b0; sweep = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; got = rdata; break; end
        end
        chk(ok, "R12 done seen", int'(ok), 1);
        @(negedge clk);
        chk(done == 1'b0, "R12 done one cycle", int'(done), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [7:0] RD_TAB [0:7] = '{8'h00, 8'h3F, 8'h01, 8'h2A, 8'h20, 8'h07, 8'h95, 8'h3E};

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic [15:0] acc;
        for (int a = 0; a < 256; a++) mem[a] = memfn(a);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!ser_clk && !ser_cs && !ser_to_rom, "R1 pins low in reset",
            int'({ser_clk, ser_cs, ser_to_rom}), 0);
        chk(!done && !width_valid, "R1 flags clear", int'({done, width_valid}), 0);
        rst = 1'b0;
        @(negedge clk);

        // First read: discovery at width 6 (R2, R4, R5, R6, R8)
        cs_rises = 0;
        run_op(8'h15, 1'b0, got);
        chk(got == memfn(8'h15), "R5 first read word", int'(got), int'(memfn(8'h15)));
        chk(width == 4'd6 && width_valid, "R4 width found", int'(width), 6);
        chk(!width_err, "R9 no error when zero seen", int'(width_err), 0);
        chk(cs_rises == 2, "R6 probe plus read", cs_rises, 2);
        chk(bad_cmd == 0, "R2 start and opcode", bad_cmd, 0);
        chk(!ser_cs && !ser_clk && !ser_to_rom, "R8 pins low after read",
            int'({ser_cs, ser_clk, ser_to_rom}), 0);

        // Table of reads at known width (R5, R6, R7)
        foreach (RD_TAB[k]) begin
            cs_rises = 0;
            run_op(RD_TAB[k], 1'b0, got);
            chk(got == memfn(int'(RD_TAB[k]) & 63), "R7 word read",
                int'(got), int'(memfn(int'(RD_TAB[k]) & 63)));
            chk(cs_rises == 1, "R6 single transfer", cs_rises, 1);
        end

        // R11: start while busy is ignored
        cs_rises = 0;
        @(negedge clk);
        start = 1'b1; addr = 8'h03;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1; addr = 8'h09;
        @(negedge clk);
        start = 1'b0;
        begin
            bit ok = 1'b0;
            int extra = 0;
            for (int i = 0; i < 60000; i++) begin
                @(negedge clk);
                if (done) begin ok = 1'b1; got = rdata; break; end
            end
            chk(ok && got == memfn(3), "R11 first request served", int'(got), int'(memfn(3)));
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (done || ser_cs) extra++;
            end
            chk(extra == 0 && cs_rises == 1, "R11 busy start dropped", extra + cs_rises, 1);
        end

        // R10: sweep with a matching signature
        acc = '0;
        for (int a = 0; a < 63; a++) acc = acc + mem[a];
        mem[63] = 16'hBABA - acc;
        cs_rises = 0;
        run_op(8'h00, 1'b1, got);
        chk(image_ok == 1'b1, "R10 sum matches", int'(image_ok), 1);
        chk(cs_rises == 64, "R10 all words read", cs_rises, 64);
        chk(got == mem[63], "R10 last word", int'(got), int'(mem[63]));

        // R10: corrupted image
        mem[10] = mem[10] ^ 16'h0001;
        run_op(8'h00, 1'b1, got);
        chk(image_ok == 1'b0, "R10 sum mismatch", int'(image_ok), 0);

        // R4 boundary: 4-bit device
        for (int a = 0; a < 256; a++) mem[a] = memfn(a);
        dev_aw = 4;
        do_reset();
        chk(!width_valid, "R1 width cleared by reset", int'(width_valid), 0);
        run_op(8'h0B, 1'b0, got);
        chk(width == 4'd4, "R4 width four", int'(width), 4);
        chk(got == memfn(11), "R5 word at width four", int'(got), int'(memfn(11)));

        // R4 boundary: full 8-bit device
        dev_aw = 8;
        do_reset();
        run_op(8'hC8, 1'b0, got);
        chk(width == 4'd8 && !width_err, "R4 width eight", int'(width), 8);
        chk(got == memfn(200), "R7 word at width eight", int'(got), int'(memfn(200)));

        // R9: device never drives the dummy zero
        mute = 1'b1;
        do_reset();
        cs_rises = 0;
        run_op(8'h05, 1'b0, got);
        chk(width_err == 1'b1, "R9 error flagged", int'(width_err), 1);
        chk(width == 4'd8, "R9 width falls back", int'(width), 8);
        chk(got == 16'hFFFF, "R9 idle line data", int'(got), 'hFFFF);
        chk(cs_rises == 2, "R9 retried once", cs_rises, 2);

        chk(viol == 0, "R3 pin timing", viol, 0);
        chk(bad_cmd == 0, "R2 opcode on every transfer", bad_cmd, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule